// File: doc/BRIEF.md
# Sliding-Window Antipodal Bit Auto-Correlator

This block keeps a running auto-correlation matrix of a stream of antipodal (+1/-1) bit vectors over a sliding window. Each bit is carried as one binary digit, so the product of two bits is a single XNOR gate. Every off-diagonal matrix entry is an up/down counter. On each update all counters move in parallel in one clock cycle. The outer product of the incoming vector is added to the matrix. The outer product of the vector that leaves the window is removed.

The matrix is symmetric and its diagonal is always a sum of +1 terms. For that reason only the upper triangle is stored, which is K(2K-1) counters for a vector of 2K bits. A combinational read port returns any entry (row, col). It swaps the two indices when row > col, and it reports a diagonal entry as the number of vectors currently in the window. While the window fills, the subtraction of the outgoing vector is suppressed for the first WIN_LEN updates after reset or clear. The logic that produces the bits, and the logic that uses the matrix, sit outside this block.

Top module: `bitcorr_window`

## Requirements
- R1: A bit value 1 means +1 and 0 means -1. The product of bits i and j is +1 exactly when the two bits are equal.
- R2: During the first WIN_LEN accepted updates after reset or clear, each off-diagonal entry (i,j) moves by +1 when bit_new[i] equals bit_new[j] and by -1 otherwise. In this phase bit_old has no effect.
- R3: Once WIN_LEN updates have been accepted, each off-diagonal entry moves by the new product minus the old product. The old product is formed from bit_old. The step is therefore +2, -2 or 0.
- R4: After the window is full, an entry whose new and old products are equal keeps its value across the update.
- R5: A read with row equal to col returns the number of vectors in the window. That number is the count of accepted updates since reset or clear, saturating at WIN_LEN.
- R6: A read of (row, col) with row > col returns the same value as a read of (col, row). The read port is combinational, so an update becomes visible on rd_data just after the clock edge that accepts it.
- R7: When clr is high at a clock edge, every entry and the fill count become zero. clr takes priority over upd_valid in the same cycle.
- R8: A cycle with upd_valid and clr both low changes no entry and no fill count, whatever the bit inputs carry.
- R9: After reset every entry and the fill count read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the matrix and the fill count |
| upd_valid | input | 1 | Accept one window update at this edge |
| bit_new | input | 2*K_USERS | Vector entering the window (1 = +1, 0 = -1) |
| bit_old | input | 2*K_USERS | Vector leaving the window |
| rd_row | input | $clog2(2*K_USERS) | Read row index |
| rd_col | input | $clog2(2*K_USERS) | Read column index |
| rd_data | output | CNT_W | Entry value, two's complement |

## Verification
Every counter result is due one edge after the update that causes it. Because the read port is combinational, the new value appears on rd_data right after that edge. The bench drives its stimulus at the falling edge and advances its reference model at the rising edge that accepts the update. At the next falling edge it sweeps every (row, col) pair, allowing a short settle delay after each address change. A clear is checked the same way, one edge after clr, including the cycle where clr and upd_valid are both high.

// File: rtl/bitcorr_pkg.sv
package bitcorr_pkg;

  // Antipodal product: equal codes give +1 (coded 1), unequal give -1 (coded 0)
  function automatic logic prod_bit(input logic a, input logic b);
    return ~(a ^ b);
  endfunction

  // Signed counter step for one entry, from the new product, the old product
  // and whether the outgoing term is subtracted
  function automatic logic signed [2:0] corr_step(input logic p_new,
                                                  input logic p_old,
                                                  input logic sub_en);
    logic signed [2:0] s;
    s = p_new ? 3'sd1 : -3'sd1;
    if (sub_en) s = s - (p_old ? 3'sd1 : -3'sd1);
    return s;
  endfunction

  // Linear slot of upper-triangle entry (lo, hi), lo < hi, in an n-wide matrix
  function automatic int pair_idx(input int lo, input int hi, input int n);
    return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

endpackage

// File: rtl/bitcorr_fill_ctrl.sv
module bitcorr_fill_ctrl #(
  parameter int WIN_LEN = 8,
  parameter int FILL_W  = $clog2(WIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  output logic [FILL_W-1:0] fill_cnt,
  output logic              sub_en
);

  assign sub_en = (fill_cnt == FILL_W'(WIN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             fill_cnt <= '0;
    else if (clr)           fill_cnt <= '0;
    else if (upd && !sub_en) fill_cnt <= fill_cnt + 1'b1;
  end

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= FILL_W'(WIN_LEN));

  // R7
  fill_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> fill_cnt == '0);

  // R3
  sub_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_en) |-> ($past(upd) && !$past(clr)));

endmodule

// File: rtl/bitcorr_cell.sv
module bitcorr_cell
  import bitcorr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             sub_en,
  input  logic             p_new,
  input  logic             p_old,
  output logic [CNT_W-1:0] cnt
);

  logic signed [2:0]   step3;
  logic [CNT_W-1:0]    step_ext;
  logic                step_zero;

  assign step3     = corr_step(p_new, p_old, sub_en);
  assign step_ext  = {{(CNT_W-3){step3[2]}}, step3};
  assign step_zero = (step3 == 3'sd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (upd && !step_zero)   cnt <= cnt + step_ext;
  end

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(cnt));

  // R4
  equal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && sub_en && (p_new == p_old)) |=> $stable(cnt));

  // R2
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && !sub_en) |=>
      cnt == $past(cnt) + ($past(p_new) ? CNT_W'(1) : {CNT_W{1'b1}}));

endmodule

// File: rtl/bitcorr_read_mux.sv
module bitcorr_read_mux
  import bitcorr_pkg::*;
#(
  parameter int VEC    = 8,
  parameter int CNT_W  = 8,
  parameter int FILL_W = 4,
  parameter int NPAIR  = VEC * (VEC - 1) / 2,
  parameter int IDX_W  = $clog2(VEC)
) (
  input  logic [CNT_W-1:0]  ent [NPAIR],
  input  logic [FILL_W-1:0] fill_cnt,
  input  logic [IDX_W-1:0]  rd_row,
  input  logic [IDX_W-1:0]  rd_col,
  output logic [CNT_W-1:0]  rd_data
);

  localparam int PIDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [IDX_W-1:0]  lo, hi;
  logic [PIDX_W-1:0] slot;

  always_comb begin
    lo   = (rd_row < rd_col) ? rd_row : rd_col;
    hi   = (rd_row < rd_col) ? rd_col : rd_row;
    slot = PIDX_W'(pair_idx(int'(lo), int'(hi), VEC));
    if (rd_row == rd_col)
      rd_data = CNT_W'(fill_cnt);
    else if (int'(hi) < VEC && int'(slot) < NPAIR)
      rd_data = ent[slot];
    else
      rd_data = '0;
  end

endmodule

// File: rtl/bitcorr_window.sv
module bitcorr_window
  import bitcorr_pkg::*;
#(
  parameter int K_USERS = 4,
  parameter int CNT_W   = 8,
  parameter int WIN_LEN = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           upd_valid,
  input  logic [2*K_USERS-1:0]           bit_new,
  input  logic [2*K_USERS-1:0]           bit_old,
  input  logic [$clog2(2*K_USERS)-1:0]   rd_row,
  input  logic [$clog2(2*K_USERS)-1:0]   rd_col,
  output logic [CNT_W-1:0]               rd_data
);

  localparam int VEC    = 2 * K_USERS;
  localparam int NPAIR  = K_USERS * (VEC - 1);
  localparam int FILL_W = $clog2(WIN_LEN + 1);
  localparam int IDX_W  = $clog2(VEC);

  logic [FILL_W-1:0] fill_cnt;
  logic              sub_en;
  logic [CNT_W-1:0]  ent [NPAIR];

  bitcorr_fill_ctrl #(.WIN_LEN(WIN_LEN), .FILL_W(FILL_W)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .upd      (upd_valid),
    .fill_cnt (fill_cnt),
    .sub_en   (sub_en)
  );

  for (genvar i = 0; i < VEC; i++) begin : g_row
    for (genvar j = i + 1; j < VEC; j++) begin : g_col
      localparam int SLOT = pair_idx(i, j, VEC);
      logic p_new, p_old;
      assign p_new = prod_bit(bit_new[i], bit_new[j]);
      assign p_old = prod_bit(bit_old[i], bit_old[j]);
      bitcorr_cell #(.CNT_W(CNT_W)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .upd    (upd_valid),
        .sub_en (sub_en),
        .p_new  (p_new),
        .p_old  (p_old),
        .cnt    (ent[SLOT])
      );
    end
  end

  bitcorr_read_mux #(
    .VEC(VEC), .CNT_W(CNT_W), .FILL_W(FILL_W), .NPAIR(NPAIR), .IDX_W(IDX_W)
  ) u_rd (
    .ent      (ent),
    .fill_cnt (fill_cnt),
    .rd_row   (rd_row),
    .rd_col   (rd_col),
    .rd_data  (rd_data)
  );

  // R9
  rst_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && rd_row == rd_col) |-> rd_data == '0);

endmodule

// File: tb/bitcorr_window_bench.sv
`timescale 1ns/10ps
module bitcorr_window_bench;

  localparam int K   = 4;
  localparam int VEC = 2 * K;
  localparam int CW  = 8;
  localparam int L   = 8;
  localparam int IW  = $clog2(VEC);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           clr = 1'b0;
  logic           upd_valid = 1'b0;
  logic [VEC-1:0] bit_new = '0;
  logic [VEC-1:0] bit_old = '0;
  logic [IW-1:0]  rd_row = '0;
  logic [IW-1:0]  rd_col = '0;
  logic [CW-1:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mat [VEC][VEC];
  int fill = 0;
  logic [VEC-1:0] hist [$];

  always #10 clk = ~clk;

  bitcorr_window #(.K_USERS(K), .CNT_W(CW), .WIN_LEN(L)) u_bitcorr_window (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd_valid(upd_valid),
    .bit_new(bit_new), .bit_old(bit_old),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  function automatic int pm(input logic a, input logic b);
    return (a == b) ? 1 : -1;
  endfunction

  task automatic model_clear();
    for (int r = 0; r < VEC; r++)
      for (int c = 0; c < VEC; c++) mat[r][c] = 0;
    fill = 0;
  endtask

  task automatic model_update(input logic [VEC-1:0] bn, input logic [VEC-1:0] bo);
    for (int r = 0; r < VEC; r++)
      for (int c = 0; c < VEC; c++)
        if (r != c) begin
          mat[r][c] += pm(bn[r], bn[c]);
          if (fill == L) mat[r][c] -= pm(bo[r], bo[c]);
        end
    if (fill < L) fill++;
  endtask

  task automatic sweep(input string tag);
    for (int r = 0; r < VEC; r++)
      for (int c = 0; c < VEC; c++) begin
        logic [CW-1:0] exp_v;
        string t;
        rd_row = IW'(r);
        rd_col = IW'(c);
        #0.1;
        exp_v = (r == c) ? CW'(fill) : CW'(mat[r][c]);
        t = (r == c) ? "R5" : ((r > c) ? "R6" : tag);
        checks++;
        if (rd_data !== exp_v) begin
          errors++;
          $display("FAIL %s entry(%0d,%0d) actual=%0d expected=%0d",
                   t, r, c, $signed(rd_data), $signed(exp_v));
        end
      end
  endtask

  task automatic step(input logic u, input logic c, input logic [VEC-1:0] bn,
                      input logic [VEC-1:0] bo, input string tag);
    @(negedge clk);
    upd_valid = u; clr = c; bit_new = bn; bit_old = bo;
    @(posedge clk);
    if (c) model_clear();
    else if (u) model_update(bn, bo);
    @(negedge clk);
    upd_valid = 1'b0; clr = 1'b0;
    sweep(tag);
  endtask

  task automatic slide(input logic [VEC-1:0] bn, input string tag);
    logic [VEC-1:0] bo;
    bo = (hist.size() >= L) ? hist[hist.size() - L] : VEC'($urandom);
    hist.push_back(bn);
    step(1'b1, 1'b0, bn, bo, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R9");

    // R8: inputs toggle without upd_valid or clr
    for (int n = 0; n < 3; n++) step(1'b0, 1'b0, VEC'($urandom), VEC'($urandom), "R8");

    // R1: known encoding, bits 0 and 1 are +1, the rest -1
    slide(8'b0000_0011, "R1");
    // R2: fill phase, bit_old carries junk that must be ignored
    for (int n = 1; n < L; n++) slide(VEC'($urandom), "R2");

    // R3: full window, true sliding
    for (int n = 0; n < 16; n++) slide(VEC'($urandom), "R3");
    slide('1, "R3");
    slide(8'hAA, "R3");
    slide(8'h55, "R3");

    // R4: outgoing vector equal to incoming one, every entry holds
    for (int n = 0; n < 3; n++) begin
      logic [VEC-1:0] v;
      v = VEC'($urandom);
      step(1'b1, 1'b0, v, v, "R4");
    end
    // R4: products equal though bits differ (complement gives same products)
    begin
      logic [VEC-1:0] v;
      v = VEC'($urandom);
      step(1'b1, 1'b0, v, ~v, "R4");
    end

    // R7: clear together with an update, clear wins
    step(1'b1, 1'b1, VEC'($urandom), VEC'($urandom), "R7");
    hist.delete();
    for (int n = 0; n < 3; n++) slide(VEC'($urandom), "R2");
    step(1'b0, 1'b1, VEC'($urandom), VEC'($urandom), "R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule